// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block runs transfers to up to four slave peripherals that share one 16-bit bus for both address and data. A local requester presents a single transfer: direction, a slave index, an offset and, for writes, a data word. The master then drives the offset on the shared bus with an address-latch strobe. It holds the cycle while it waits for the selected slave to pull an active-low ready line, runs a one-cycle data phase and a one-cycle recovery phase, and returns to idle. The phases always run in this order: address, wait, data, recovery, idle.

Each slave owns a 1 MB window in the requester's address space. Only the lowest 64 KB of that window reach the slave: a request whose offset lies above 64 KB is refused with an error pulse and no bus activity. A programmable limit caps the number of wait cycles. If ready never comes within that limit, the cycle is abandoned, the chip select is released and an error pulse is returned. Reads release the shared bus after the address phase and capture the slave's word on the clock edge at which ready is seen.

Top module: `muxbus_master`

## Requirements
- R1: After reset, all chip selects are high, the strobe, bus drive and direction outputs are low, `req_ready` is high, and `done` and `err` are low.
- R2: A request is taken only while `req_ready` is high. In the next cycle the address phase lasts exactly one cycle, and in it `bus_ale` is 1, `bus_ad_oe` is 1, `bus_ad_out` equals `req_addr[15:0]`, and only chip select `req_addr[21:20]` is low (index 0 is `bus_cs_n[0]`).
- R3: A request with any of `req_addr[19:16]` set lies outside the slave's 64 KB space. It starts no bus cycle, and `err` pulses high for one cycle in the following cycle.
- R4: For a write, `bus_wnr` is 1 from the address phase through the data phase, and `req_wdata` is driven with `bus_ad_oe` high in the wait and data phases. A write leaves `rdata` unchanged.
- R5: For a read, `bus_wnr` is 0 and `bus_ad_oe` is 0 after the address phase. `rdata` takes the value of `bus_ad_in` from the same clock edge at which `bus_rdy_n` is first sampled low during the wait phase.
- R6: When `bus_rdy_n` is sampled low in the wait phase, the next cycle is the data phase, in which `done` is high for one cycle with the chip select still low. One recovery cycle follows with all chip selects high and `req_ready` low, and then the block is idle.
- R7: If `bus_rdy_n` stays high for max(`tmo_limit`,1) wait cycles, the cycle ends. In the next cycle `err` is high for one cycle, `done` stays low, all chip selects are high and `req_ready` is high.
- R8: Ready sampled low in the last allowed wait cycle completes the transfer normally, with no error.
- R9: `req_valid` held high while a transfer is in progress starts no further address phase.
- R10: At most one chip select is low at any time, and `bus_ale` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | [21:20] slave index, [19:0] offset in the slave's 1 MB window |
| req_wdata | input | 16 | Write data |
| tmo_limit | input | 8 | Maximum wait cycles (0 acts as 1) |
| req_ready | output | 1 | Idle, a request can be taken |
| done | output | 1 | Data phase of a completed transfer |
| err | output | 1 | One-cycle pulse on timeout or out-of-window request |
| rdata | output | 16 | Last word read |
| bus_ad_out | output | 16 | Shared bus, value driven |
| bus_ad_oe | output | 1 | Shared bus drive enable |
| bus_ad_in | input | 16 | Shared bus, value seen |
| bus_ale | output | 1 | Address-latch strobe |
| bus_wnr | output | 1 | Direction: 1 write, 0 read |
| bus_cs_n | output | 4 | Active-low slave chip selects |
| bus_rdy_n | input | 1 | Active-low ready from the selected slave |

## Verification
The sweep covers every slave index in both directions, with ready arriving after zero to three wait cycles. This separates chip-select decoding, bus drive direction and the placement of the data phase after ready. During a read the slave's bus word is held at a wrong value until the ready cycle, so a capture one cycle too early or too late shows up. Timeouts are run with limits 0, 1, 2 and 5, and ready is also given in the last allowed cycle, which tells an off-by-one in the wait counter from a correct one. Offsets above 64 KB and a request held high during a busy cycle show whether unwanted bus cycles are started.

// File: rtl/mbm_pkg.sv
`timescale 1ns/1ps
package mbm_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ADDR = 3'd1,
        PH_WAIT = 3'd2,
        PH_DATA = 3'd3,
        PH_REC  = 3'd4
    } phase_e;

    // Bus controls decoded from the current phase
    typedef struct packed {
        logic ale;
        logic drive;
        logic wnr;
        logic sel_en;
        logic fin;
    } bus_ctl_t;

    localparam int CNT_MAX_W = 16;

    function automatic bus_ctl_t ctl_of(phase_e ph, logic wr);
        bus_ctl_t c;
        c = '0;
        case (ph)
            PH_ADDR: begin
                c.ale    = 1'b1;
                c.drive  = 1'b1;
                c.wnr    = wr;
                c.sel_en = 1'b1;
            end
            PH_WAIT: begin
                c.drive  = wr;
                c.wnr    = wr;
                c.sel_en = 1'b1;
            end
            PH_DATA: begin
                c.drive  = wr;
                c.wnr    = wr;
                c.sel_en = 1'b1;
                c.fin    = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

    // True when the wait cycle numbered cnt (from 0) is the last allowed one
    function automatic logic limit_reached(logic [CNT_MAX_W-1:0] cnt,
                                           logic [CNT_MAX_W-1:0] lim);
        return ({1'b0, cnt} + 17'd1) >= {1'b0, lim};
    endfunction

endpackage

// File: rtl/mbm_cs_decode.sv
`timescale 1ns/1ps
module mbm_cs_decode #(
    parameter int NUM_CS = 4,
    parameter int SEL_W  = 2
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic              en,
    output logic [NUM_CS-1:0] cs_n
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_n[i] = !(en && (sel == SEL_W'(i)));
    end
endmodule

// File: rtl/mbm_wait_timer.sv
`timescale 1ns/1ps
module mbm_wait_timer
    import mbm_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && limit_reached(16'(cnt_q), 16'(limit));
endmodule

// File: rtl/mbm_phase_fsm.sv
`timescale 1ns/1ps
module mbm_phase_fsm
    import mbm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   rdy_seen,
    input  logic   expired,
    output phase_e phase
);
    phase_e nxt;

    always_comb begin
        nxt = phase;
        case (phase)
            PH_IDLE: if (start) nxt = PH_ADDR;
            PH_ADDR: nxt = PH_WAIT;
            PH_WAIT: begin
                if (rdy_seen)     nxt = PH_DATA;
                else if (expired) nxt = PH_IDLE;
            end
            PH_DATA: nxt = PH_REC;
            PH_REC:  nxt = PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= nxt;
    end
endmodule

// File: rtl/muxbus_master.sv
`timescale 1ns/1ps
module muxbus_master
    import mbm_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_CS   = 4,
    parameter int REGION_W = 20,
    parameter int TMO_W    = 8,
    localparam int SEL_W   = $clog2(NUM_CS),
    localparam int REQ_AW  = REGION_W + SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [REQ_AW-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [TMO_W-1:0]  tmo_limit,
    output logic              req_ready,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    input  logic [DATA_W-1:0] bus_ad_in,
    output logic              bus_ale,
    output logic              bus_wnr,
    output logic [NUM_CS-1:0] bus_cs_n,
    input  logic              bus_rdy_n
);
    phase_e            phase;
    bus_ctl_t          ctl;
    logic              out_of_window;
    logic              start;
    logic              rdy_seen;
    logic              expired;
    logic              x_write;
    logic [SEL_W-1:0]  x_sel;
    logic [DATA_W-1:0] x_addr;
    logic [DATA_W-1:0] x_wdata;
    logic              err_q;

    // Offset bits above the slave's space must be zero
    assign out_of_window = |req_addr[REGION_W-1:DATA_W];
    assign start         = req_valid && (phase == PH_IDLE) && !out_of_window;
    assign rdy_seen      = (phase == PH_WAIT) && !bus_rdy_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_write <= 1'b0;
            x_sel   <= '0;
            x_addr  <= '0;
            x_wdata <= '0;
        end else if (start) begin
            x_write <= req_write;
            x_sel   <= req_addr[REQ_AW-1:REGION_W];
            x_addr  <= req_addr[DATA_W-1:0];
            x_wdata <= req_wdata;
        end
    end

    mbm_phase_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .rdy_seen (rdy_seen),
        .expired  (expired),
        .phase    (phase)
    );

    mbm_wait_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (phase == PH_WAIT),
        .limit   (tmo_limit),
        .expired (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            err_q <= 1'b0;
        end else begin
            if (rdy_seen && !x_write) rdata <= bus_ad_in;
            err_q <= ((phase == PH_WAIT) && !rdy_seen && expired) ||
                     (req_valid && (phase == PH_IDLE) && out_of_window);
        end
    end

    assign ctl        = ctl_of(phase, x_write);
    assign bus_ale    = ctl.ale;
    assign bus_ad_oe  = ctl.drive;
    assign bus_wnr    = ctl.wnr;
    assign done       = ctl.fin;
    assign err        = err_q;
    assign req_ready  = (phase == PH_IDLE);
    assign bus_ad_out = ctl.ale ? x_addr : (ctl.drive ? x_wdata : '0);

    mbm_cs_decode #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_cs (
        .sel  (x_sel),
        .en   (ctl.sel_en),
        .cs_n (bus_cs_n)
    );
endmodule

// File: rtl/mbm_checker.sv
`timescale 1ns/1ps
module mbm_checker #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              done,
    input logic              err,
    input logic              bus_ale,
    input logic              bus_ad_oe,
    input logic              bus_wnr,
    input logic [NUM_CS-1:0] bus_cs_n,
    input logic              bus_rdy_n
);
    localparam logic [NUM_CS-1:0] ALL_OFF = '1;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (bus_cs_n == ALL_OFF && !bus_ad_oe && !bus_ale));

    p_ale_one_cs_r2: assert property (@(posedge clk) disable iff (rst)
        bus_ale |-> ($countones(~bus_cs_n) == 1 && bus_ad_oe));

    p_wnr_held_r4: assert property (@(posedge clk) disable iff (rst)
        (!bus_ale && bus_cs_n != ALL_OFF) |-> (bus_wnr == $past(bus_wnr)));

    p_read_release_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_ale && !bus_wnr) |=> !bus_ad_oe);

    p_ready_to_data_r6: assert property (@(posedge clk) disable iff (rst)
        (!bus_ale && !done && bus_cs_n != ALL_OFF && !bus_rdy_n) |=> done);

    p_recovery_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> (bus_cs_n == ALL_OFF && !done && !req_ready));

    p_err_released_r7: assert property (@(posedge clk) disable iff (rst)
        err |-> (bus_cs_n == ALL_OFF && req_ready && !done));

    p_cs_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~bus_cs_n));

    p_ale_single_r10: assert property (@(posedge clk) disable iff (rst)
        bus_ale |=> !bus_ale);
endmodule

bind muxbus_master mbm_checker #(.NUM_CS(NUM_CS)) u_chk (.*);

// File: tb/muxbus_master_tb.sv
`timescale 1ns/1ps
module muxbus_master_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_write;
    logic [21:0] req_addr;
    logic [15:0] req_wdata;
    logic [7:0]  tmo_limit;
    logic        req_ready;
    logic        done;
    logic        err;
    logic [15:0] rdata;
    logic [15:0] bus_ad_out;
    logic        bus_ad_oe;
    logic [15:0] bus_ad_in;
    logic        bus_ale;
    logic        bus_wnr;
    logic [3:0]  bus_cs_n;
    logic        bus_rdy_n;

    int n_checks = 0;
    int n_errors = 0;
    logic [15:0] last_rd = 16'h0;

    always #10 clk = ~clk;

    muxbus_master u_dut (.*);

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input int slave, input logic [15:0] a,
                        input logic [15:0] wd, input int delay, input int lim);
        int eff;
        logic [3:0]  sel_n;
        logic [15:0] rd_val;
        bit hit;
        eff    = (lim == 0) ? 1 : lim;
        sel_n  = ~(4'b0001 << slave);
        rd_val = a ^ 16'h5A5A ^ 16'(delay);
        hit    = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready before request", 32'(req_ready), 32'd1);
        tmo_limit = 8'(lim);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {2'(slave), 4'h0, a};
        req_wdata = wd;
        bus_rdy_n = 1'b1;
        bus_ad_in = ~rd_val;
        @(negedge clk);
        chk(bus_ale == 1'b1, "R2 ale", 32'(bus_ale), 32'd1);
        chk(bus_cs_n == sel_n, "R2 cs", 32'(bus_cs_n), 32'(sel_n));
        chk(bus_ad_out == a, "R2 address", 32'(bus_ad_out), 32'(a));
        chk(bus_ad_oe == 1'b1, "R2 oe", 32'(bus_ad_oe), 32'd1);
        chk(bus_wnr == wr, "R4/R5 wnr in address phase", 32'(bus_wnr), 32'(wr));
        // R9: keep asking for another slave while busy
        req_addr = {2'(slave + 1), 4'h0, ~a};
        for (int k = 0; k < eff; k++) begin
            @(negedge clk);
            if (k == 0) req_valid = 1'b0;
            chk(bus_ale == 1'b0, "R9 no new address phase", 32'(bus_ale), 32'd0);
            chk(bus_cs_n == sel_n, "R6 cs held in wait", 32'(bus_cs_n), 32'(sel_n));
            chk(bus_ad_oe == wr, "R4/R5 oe in wait", 32'(bus_ad_oe), 32'(wr));
            chk(bus_wnr == wr, "R4 wnr in wait", 32'(bus_wnr), 32'(wr));
            chk(done == 1'b0, "R6 no done in wait", 32'(done), 32'd0);
            if (wr) chk(bus_ad_out == wd, "R4 write data", 32'(bus_ad_out), 32'(wd));
            if (k == delay) begin
                bus_rdy_n = 1'b0;
                bus_ad_in = rd_val;
                hit = 1'b1;
                break;
            end
        end
        if (hit) begin
            @(negedge clk);
            bus_rdy_n = 1'b1;
            bus_ad_in = 16'h0;
            chk(done == 1'b1, "R6/R8 done", 32'(done), 32'd1);
            chk(err == 1'b0, "R8 no error", 32'(err), 32'd0);
            chk(bus_cs_n == sel_n, "R6 cs in data phase", 32'(bus_cs_n), 32'(sel_n));
            if (!wr) begin
                chk(rdata == rd_val, "R5 read capture", 32'(rdata), 32'(rd_val));
                last_rd = rd_val;
            end else begin
                chk(bus_ad_out == wd && bus_ad_oe, "R4 data phase drive",
                    32'(bus_ad_out), 32'(wd));
                chk(rdata == last_rd, "R4 rdata kept", 32'(rdata), 32'(last_rd));
            end
            @(negedge clk);
            chk(bus_cs_n == 4'hF, "R6 recovery cs", 32'(bus_cs_n), 32'hF);
            chk(done == 1'b0 && req_ready == 1'b0, "R6 recovery state",
                32'({done, req_ready}), 32'd0);
            chk(bus_ad_oe == 1'b0, "R6 recovery oe", 32'(bus_ad_oe), 32'd0);
            @(negedge clk);
            chk(req_ready == 1'b1, "R6 back to idle", 32'(req_ready), 32'd1);
            chk(bus_ale == 1'b0, "R9 no second transfer", 32'(bus_ale), 32'd0);
        end else begin
            @(negedge clk);
            chk(err == 1'b1, "R7 timeout error", 32'(err), 32'd1);
            chk(done == 1'b0, "R7 no done", 32'(done), 32'd0);
            chk(bus_cs_n == 4'hF, "R7 cs released", 32'(bus_cs_n), 32'hF);
            chk(req_ready == 1'b1, "R7 idle", 32'(req_ready), 32'd1);
            chk(rdata == last_rd, "R7 rdata kept", 32'(rdata), 32'(last_rd));
            @(negedge clk);
            chk(err == 1'b0, "R7 error single pulse", 32'(err), 32'd0);
        end
    endtask

    task automatic out_of_window(input int slave, input logic [3:0] hi);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = {2'(slave), hi, 16'h1234};
        @(negedge clk);
        req_valid = 1'b0;
        chk(err == 1'b1, "R3 error pulse", 32'(err), 32'd1);
        chk(bus_ale == 1'b0 && bus_cs_n == 4'hF, "R3 no bus cycle",
            32'({bus_ale, bus_cs_n}), 32'hF);
        chk(req_ready == 1'b1, "R3 still idle", 32'(req_ready), 32'd1);
        @(negedge clk);
        chk(err == 1'b0 && bus_cs_n == 4'hF, "R3 pulse ends",
            32'({err, bus_cs_n}), 32'hF);
    endtask

    initial begin
        #(200000 * 20);
        n_errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_wdata = '0; tmo_limit = 8'd4; bus_ad_in = '0; bus_rdy_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(bus_cs_n == 4'hF, "R1 cs", 32'(bus_cs_n), 32'hF);
        chk({bus_ale, bus_ad_oe, bus_wnr} == 3'b0, "R1 strobes",
            32'({bus_ale, bus_ad_oe, bus_wnr}), 32'd0);
        chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
        chk({done, err} == 2'b0, "R1 status", 32'({done, err}), 32'd0);
        rst = 1'b0;
        // R2 R4 R5 R6: every slave, both directions, several ready delays
        for (int w = 0; w < 2; w++)
            for (int s = 0; s < 4; s++)
                for (int d = 0; d < 4; d++)
                    xfer(w[0], s, 16'(16'h1111 * (s + 1) + d * 7),
                         16'(16'hC0DE ^ (s << 8) ^ d), d, 4);
        // R7 timeouts across limits, including 0 acting as 1
        for (int w = 0; w < 2; w++) begin
            xfer(w[0], 1, 16'hA0A0, 16'h0F0F, 99, 0);
            xfer(w[0], 2, 16'hB1B1, 16'hF0F0, 99, 1);
            xfer(w[0], 3, 16'hC2C2, 16'h3C3C, 99, 2);
            xfer(w[0], 0, 16'hD3D3, 16'hC3C3, 99, 5);
        end
        // R8 ready in the last allowed cycle
        xfer(1'b0, 2, 16'h7E57, 16'h0, 4, 5);
        xfer(1'b1, 3, 16'h8E57, 16'h4321, 4, 5);
        xfer(1'b0, 0, 16'hFFFF, 16'h0, 0, 0);
        // R3 offsets beyond 64 KB
        out_of_window(0, 4'h1);
        out_of_window(3, 4'h8);
        xfer(1'b0, 1, 16'h0001, 16'h0, 1, 3);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule